// File: doc/BRIEF.md
# Audio Serial Clock Generator

This block produces the clocks of a serial audio port when the port drives its own clocks. All of its logic runs on one source clock. A prescaler divides that clock into a root clock. From the root clock the block derives a bit clock and a frame clock. Each of these is a programmable multiple of the frame rate. A one-cycle strobe marks the start of every frame.

The ratios come from two-bit codes whose order is not monotonic. When auto-select is on and no ratio is requested, the block instead picks the ratios from the sample width. Before starting, it checks the resulting combination and refuses to start on an illegal one. In that case it raises an error flag.

When the port follows an external clock master, the external bit and frame clocks pass straight through and the dividers stay idle. The frame strobe then comes from a synchronised copy of the external frame clock. All pins here are plain control and status levels, so no valid/ready handshake is involved.

Top module: `aclk_gen`

## Requirements
- R1: The root-ratio code sets the number of root-clock cycles per frame: code 0 gives 256, 1 gives 512, 2 gives 384 and 3 gives 768. One frame lasts that ratio times the prescaler division, counted in source cycles.
- R2: The bit-ratio code sets the number of bit-clock periods per frame: code 0 gives 32, 1 gives 48, 2 gives 16 and 3 gives 24.
- R3: The prescaler word holds the division minus one in bits [PSR_W+7:8], and its enable is bit 0.
  - When enabled, one root-clock period is that value plus one source cycles, and rclk_o is high for the first ceil(period/2) of them.
  - With the enable clear, the division is 1.
- R4: The sample-width code selects the sample width: 0 is 16 bits, 1 is 8, 2 is 24, and 3 is reserved.
  - A configuration is illegal if the width is reserved, if a 24-bit width meets a root ratio of 256 or 512, or if the root ratio is not a multiple of the bit ratio.
  - In master mode an illegal configuration sets cfg_err_o one cycle later and the clocks do not start.
  - cfg_err_o stays low in slave mode.
- R5: With auto-select on and no bit ratio requested, the bit ratio is twice the sample width.
- R6: With auto-select on and no root ratio requested, the root ratio is 256 when the bit ratio is 16 or 32, and 384 otherwise.
- R7: The bit clock has a 50 % duty cycle. It changes only at the end of a root-clock cycle, and each half lasts (root ratio / bit ratio) / 2 root-clock cycles.
- R8: The frame clock is low in the first half of each frame and high in the second. Each half lasts bit ratio / 2 bit-clock periods, and the frame clock changes only together with a falling bit-clock edge.
- R9: frame_start_o is a one-cycle pulse. It fires in the cycle after the clocks start and again each time the frame clock falls.
- R10: A configuration change made while the clocks run takes effect at the next frame boundary. If the new configuration is illegal, the clocks keep their old ratios and cfg_err_o rises.
- R11: In slave mode:
  - bclk_o and lrclk_o follow ext_bclk_i and ext_lrclk_i, and rclk_o stays low.
  - Each falling edge of ext_lrclk_i gives exactly one frame_start_o pulse after SYNC_N+1 cycles.
- R12: After reset, and while master mode is idle, rclk_o, bclk_o, lrclk_o, frame_start_o and cfg_err_o are low.
- R13: Dropping run_i stops the clocks: from the next cycle on, rclk_o, bclk_o and lrclk_o are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Active-low synchronous reset |
| master_i | input | 1 | 1: block drives the clocks, 0: clocks come from outside |
| run_i | input | 1 | Request to run the clocks (master mode) |
| auto_sel_i | input | 1 | Allow ratios to be chosen from the sample width |
| rclk_req_i | input | 1 | Root ratio taken from rclk_code_i even when auto-select is on |
| rclk_code_i | input | 2 | Root-ratio code |
| bclk_req_i | input | 1 | Bit ratio taken from bclk_code_i even when auto-select is on |
| bclk_code_i | input | 2 | Bit-ratio code |
| width_code_i | input | 2 | Sample-width code |
| psr_i | input | PSR_W+8 | Prescaler word: division minus one at [PSR_W+7:8], enable at bit 0 |
| ext_bclk_i | input | 1 | External bit clock (slave mode) |
| ext_lrclk_i | input | 1 | External frame clock (slave mode) |
| rclk_o | output | 1 | Root clock |
| bclk_o | output | 1 | Bit clock |
| lrclk_o | output | 1 | Frame clock |
| frame_start_o | output | 1 | One-cycle frame-start strobe |
| cfg_err_o | output | 1 | Illegal ratio configuration flag |

## Verification
The bench builds the block with PSR_W = 8 and SYNC_N = 2. It drives prescaler values of 1 to 3, which keeps even a 768-ratio frame a few thousand cycles long. That makes every root and bit ratio code reachable, both alone and in random mixes, along with the odd-division duty rule of the root clock. With two synchroniser stages, a slave-mode strobe arrives three cycles after the external frame edge, so the bench can count the pulses inside short windows.

// File: rtl/aclk_pkg.sv
package aclk_pkg;

  localparam int RFS_W  = 10;  // root ratio up to 768
  localparam int BFS_W  = 6;   // bit ratio up to 48
  localparam int HALF_W = 6;   // half-period counters

  typedef struct packed {
    logic [HALF_W-1:0] bhalf;  // root cycles per bit-clock half
    logic [HALF_W-1:0] lhalf;  // bit periods per frame half
  } ratio_t;

  function automatic logic [RFS_W-1:0] rfs_of(input logic [1:0] code);
    case (code)
      2'd0:    return 10'd256;
      2'd1:    return 10'd512;
      2'd2:    return 10'd384;
      default: return 10'd768;
    endcase
  endfunction

  function automatic logic [BFS_W-1:0] bfs_of(input logic [1:0] code);
    case (code)
      2'd0:    return 6'd32;
      2'd1:    return 6'd48;
      2'd2:    return 6'd16;
      default: return 6'd24;
    endcase
  endfunction

  function automatic logic [BFS_W-1:0] width_of(input logic [1:0] code);
    case (code)
      2'd0:    return 6'd16;
      2'd1:    return 6'd8;
      2'd2:    return 6'd24;
      default: return 6'd0;
    endcase
  endfunction

endpackage

// File: rtl/aclk_cfg.sv
module aclk_cfg
  import aclk_pkg::*;
(
  input  logic       auto_sel_i,
  input  logic       rclk_req_i,
  input  logic [1:0] rclk_code_i,
  input  logic       bclk_req_i,
  input  logic [1:0] bclk_code_i,
  input  logic [1:0] width_code_i,
  output ratio_t     ratio_o,
  output logic       illegal_o
);

  logic [BFS_W-1:0] width;
  logic [BFS_W-1:0] bfs;
  logic [RFS_W-1:0] rfs;
  logic [RFS_W-1:0] bfs_safe;
  logic [RFS_W-1:0] quot;

  always_comb begin
    width = width_of(width_code_i);
    if (auto_sel_i && !bclk_req_i) bfs = BFS_W'(width << 1);
    else                           bfs = bfs_of(bclk_code_i);

    if (auto_sel_i && !rclk_req_i)
      rfs = (bfs == 6'd16 || bfs == 6'd32) ? 10'd256 : 10'd384;
    else
      rfs = rfs_of(rclk_code_i);

    bfs_safe  = (bfs == '0) ? RFS_W'(1) : RFS_W'(bfs);
    quot      = rfs / bfs_safe;

    illegal_o = (width == '0)
             || ((width == 6'd24) && (rfs == 10'd256 || rfs == 10'd512))
             || (bfs == '0)
             || ((rfs % bfs_safe) != '0);

    ratio_o.bhalf = HALF_W'(quot >> 1);
    ratio_o.lhalf = HALF_W'(bfs >> 1);
  end

endmodule

// File: rtl/aclk_prescale.sv
module aclk_prescale #(
  parameter int PSR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [PSR_W-1:0] div_i,
  output logic             tick_o,
  output logic             rclk_o
);

  logic [PSR_W-1:0] pcnt_q;
  logic [PSR_W:0]   rhalf;

  always_ff @(posedge clk) begin
    if (!rst_n || !run_i)  pcnt_q <= '0;
    else if (pcnt_q == div_i) pcnt_q <= '0;
    else                   pcnt_q <= pcnt_q + PSR_W'(1);
  end

  always_comb begin
    rhalf  = {1'b0, div_i >> 1} + (PSR_W+1)'(1);
    tick_o = run_i && (pcnt_q == div_i);
    rclk_o = run_i && ({1'b0, pcnt_q} < rhalf);
  end

endmodule

// File: rtl/aclk_frame.sv
module aclk_frame
  import aclk_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   run_i,
  input  logic   tick_i,
  input  ratio_t ratio_i,
  output logic   bclk_o,
  output logic   lrclk_o,
  output logic   boundary_o
);

  logic [HALF_W-1:0] bcnt_q;
  logic [HALF_W-1:0] lcnt_q;
  logic              bclk_q;
  logic              lr_q;
  logic              bwrap;
  logic              lwrap;

  assign bwrap = (bcnt_q == ratio_i.bhalf - HALF_W'(1));
  assign lwrap = (lcnt_q == ratio_i.lhalf - HALF_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n || !run_i) begin
      bcnt_q <= '0;
      lcnt_q <= '0;
      bclk_q <= 1'b0;
      lr_q   <= 1'b0;
    end else if (tick_i) begin
      if (bwrap) begin
        bcnt_q <= '0;
        bclk_q <= ~bclk_q;
        if (bclk_q) begin
          if (lwrap) begin
            lcnt_q <= '0;
            lr_q   <= ~lr_q;
          end else begin
            lcnt_q <= lcnt_q + HALF_W'(1);
          end
        end
      end else begin
        bcnt_q <= bcnt_q + HALF_W'(1);
      end
    end
  end

  assign bclk_o     = bclk_q;
  assign lrclk_o    = lr_q;
  assign boundary_o = tick_i && bwrap && bclk_q && lwrap && lr_q;

endmodule

// File: rtl/aclk_sync.sv
module aclk_sync #(
  parameter int SYNC_N = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic fall_o
);

  logic [SYNC_N-1:0] s_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s_q    <= '0;
      prev_q <= 1'b0;
    end else begin
      s_q    <= {s_q[SYNC_N-2:0], d_i};
      prev_q <= s_q[SYNC_N-1];
    end
  end

  assign fall_o = prev_q && !s_q[SYNC_N-1];

endmodule

// File: rtl/aclk_gen.sv
module aclk_gen
  import aclk_pkg::*;
#(
  parameter int PSR_W  = 8,
  parameter int SYNC_N = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             master_i,
  input  logic             run_i,
  input  logic             auto_sel_i,
  input  logic             rclk_req_i,
  input  logic [1:0]       rclk_code_i,
  input  logic             bclk_req_i,
  input  logic [1:0]       bclk_code_i,
  input  logic [1:0]       width_code_i,
  input  logic [PSR_W+7:0] psr_i,
  input  logic             ext_bclk_i,
  input  logic             ext_lrclk_i,
  output logic             rclk_o,
  output logic             bclk_o,
  output logic             lrclk_o,
  output logic             frame_start_o,
  output logic             cfg_err_o
);

  localparam int PSR_LSB = 8;
  localparam int PSR_EN  = 0;

  ratio_t           live_ratio;
  ratio_t           cur_ratio;
  logic             live_bad;
  logic [PSR_W-1:0] live_div;
  logic [PSR_W-1:0] cur_div;
  logic             active_q;
  logic             start;
  logic             apply;
  logic             tick;
  logic             boundary;
  logic             pre_rclk;
  logic             gen_bclk;
  logic             gen_lrclk;
  logic             slave_fall;
  logic             fs_q;
  logic             err_q;
  logic             unused_psr_bits;

  aclk_cfg u_cfg (
    .auto_sel_i   (auto_sel_i),
    .rclk_req_i   (rclk_req_i),
    .rclk_code_i  (rclk_code_i),
    .bclk_req_i   (bclk_req_i),
    .bclk_code_i  (bclk_code_i),
    .width_code_i (width_code_i),
    .ratio_o      (live_ratio),
    .illegal_o    (live_bad)
  );

  assign live_div        = psr_i[PSR_EN] ? psr_i[PSR_LSB +: PSR_W] : '0;
  assign unused_psr_bits = ^psr_i[PSR_LSB-1:PSR_EN+1];

  assign start = !active_q && master_i && run_i && !live_bad;
  assign apply = start || (boundary && !live_bad);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q  <= 1'b0;
      cur_ratio <= '0;
      cur_div   <= '0;
      fs_q      <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      active_q <= active_q ? (master_i && run_i) : start;
      if (apply) begin
        cur_ratio <= live_ratio;
        cur_div   <= live_div;
      end
      fs_q  <= master_i ? (start || boundary) : slave_fall;
      err_q <= master_i && live_bad;
    end
  end

  aclk_prescale #(.PSR_W(PSR_W)) u_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (active_q),
    .div_i  (cur_div),
    .tick_o (tick),
    .rclk_o (pre_rclk)
  );

  aclk_frame u_frame (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_i      (active_q),
    .tick_i     (tick),
    .ratio_i    (cur_ratio),
    .bclk_o     (gen_bclk),
    .lrclk_o    (gen_lrclk),
    .boundary_o (boundary)
  );

  aclk_sync #(.SYNC_N(SYNC_N)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .d_i    (ext_lrclk_i),
    .fall_o (slave_fall)
  );

  assign rclk_o        = master_i && pre_rclk;
  assign bclk_o        = master_i ? (active_q && gen_bclk)  : ext_bclk_i;
  assign lrclk_o       = master_i ? (active_q && gen_lrclk) : ext_lrclk_i;
  assign frame_start_o = fs_q;
  assign cfg_err_o     = err_q;

endmodule

// File: rtl/aclk_gen_chk.sv
module aclk_gen_chk (
  input logic clk,
  input logic rst_n,
  input logic master_i,
  input logic active_q,
  input logic tick,
  input logic live_bad,
  input logic rclk_o,
  input logic bclk_o,
  input logic lrclk_o,
  input logic frame_start_o,
  input logic cfg_err_o
);

  p_single_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    master_i && $past(master_i) && frame_start_o |=> !frame_start_o);

  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    master_i && !active_q |-> !bclk_o && !lrclk_o && !rclk_o);

  p_start_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active_q) |-> $past(!live_bad));

  p_err_master_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !master_i |=> !cfg_err_o);

  p_bclk_on_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
    master_i && active_q && !tick |=> (!active_q || !master_i || $stable(bclk_o)));

  p_lr_with_bclk_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    master_i && $past(master_i) && active_q && $past(active_q) && !$stable(lrclk_o)
      |-> $fell(bclk_o));

  p_slave_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !master_i |=> !active_q);

endmodule

bind aclk_gen aclk_gen_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .master_i      (master_i),
  .active_q      (active_q),
  .tick          (tick),
  .live_bad      (live_bad),
  .rclk_o        (rclk_o),
  .bclk_o        (bclk_o),
  .lrclk_o       (lrclk_o),
  .frame_start_o (frame_start_o),
  .cfg_err_o     (cfg_err_o)
);

// File: tb/aclk_gen_bench.sv
module aclk_gen_bench;
  localparam int PSR_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic master = 0, run = 0, auto_sel = 0, rreq = 0, breq = 0;
  logic [1:0] rcode = 0, bcode = 0, wcode = 0;
  logic [PSR_W+7:0] psr = '0;
  logic ebclk = 0, elrclk = 0;
  logic rclk_o, bclk_o, lrclk_o, frame_start_o, cfg_err_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  aclk_gen #(.PSR_W(PSR_W), .SYNC_N(2)) u_aclk_gen (
    .clk(clk), .rst_n(rst_n), .master_i(master), .run_i(run),
    .auto_sel_i(auto_sel), .rclk_req_i(rreq), .rclk_code_i(rcode),
    .bclk_req_i(breq), .bclk_code_i(bcode), .width_code_i(wcode),
    .psr_i(psr), .ext_bclk_i(ebclk), .ext_lrclk_i(elrclk),
    .rclk_o(rclk_o), .bclk_o(bclk_o), .lrclk_o(lrclk_o),
    .frame_start_o(frame_start_o), .cfg_err_o(cfg_err_o)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000) begin
      errors = errors + 1;
      $display("FAIL watchdog actual %0d expected %0d", cyc, 190000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int e_rfs(input int c);
    case (c) 0: return 256; 1: return 512; 2: return 384; default: return 768; endcase
  endfunction
  function automatic int e_bfs(input int c);
    case (c) 0: return 32; 1: return 48; 2: return 16; default: return 24; endcase
  endfunction
  function automatic int e_wid(input int c);
    case (c) 0: return 16; 1: return 8; 2: return 24; default: return 0; endcase
  endfunction

  task automatic wait_fs(output bit got);
    got = 0;
    for (int i = 0; i < 10000; i++) begin
      @(negedge clk);
      if (frame_start_o) begin got = 1; break; end
    end
  endtask

  task automatic measure(output int len, output int bri, output int rri,
                         output int lhi, output int bhi);
    bit pb, pr;
    pb = bclk_o; pr = rclk_o; len = 0; bri = 0; rri = 0; lhi = 0; bhi = 0;
    for (int i = 0; i < 10000; i++) begin
      @(negedge clk);
      len++;
      if (bclk_o && !pb) bri++;
      if (rclk_o && !pr) rri++;
      if (lrclk_o) lhi++;
      if (bclk_o) bhi++;
      pb = bclk_o; pr = rclk_o;
      if (frame_start_o) break;
    end
  endtask

  task automatic halt();
    run = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic trial(input string tl, input string tb_, input bit a, input bit rr,
                       input int rc, input bit br, input int bc, input int wc,
                       input int val, input bit en);
    int w, b, r, d, len, bri, rri, lhi, bhi, fs_cnt, bact;
    bit legal, got;
    halt();
    master = 1; auto_sel = a; rreq = rr; rcode = 2'(rc); breq = br;
    bcode = 2'(bc); wcode = 2'(wc);
    psr = '0; psr[8 +: PSR_W] = PSR_W'(val); psr[0] = en;
    w = e_wid(wc);
    b = (a && !br) ? 2 * w : e_bfs(bc);
    if (a && !rr) r = (b == 16 || b == 32) ? 256 : 384;
    else r = e_rfs(rc);
    d = en ? val + 1 : 1;
    legal = (w != 0) && !(w == 24 && (r == 256 || r == 512)) && (b != 0) && (r % b == 0);
    @(negedge clk);
    run = 1;
    if (!legal) begin
      fs_cnt = 0; bact = 0;
      for (int i = 0; i < 12; i++) begin
        @(negedge clk);
        if (frame_start_o) fs_cnt++;
        if (bclk_o || rclk_o) bact++;
      end
      check(cfg_err_o == 1'b1, "R4 error flag", int'(cfg_err_o), 1);
      check(fs_cnt == 0 && bact == 0, "R4 no start", fs_cnt + bact, 0);
    end else begin
      wait_fs(got);
      check(got, "R9 start strobe", int'(got), 1);
      measure(len, bri, rri, lhi, bhi);
      check(len == r * d, tl, len, r * d);
      check(bri == b, tb_, bri, b);
      if (d > 1) check(rri == r, "R3 root cycles", rri, r);
      check(lhi == len / 2, "R8 frame clock halves", lhi, len / 2);
      check(bhi == len / 2, "R7 bit clock duty", bhi, len / 2);
      check(cfg_err_o == 1'b0, "R4 no error", int'(cfg_err_o), 0);
    end
  endtask

  initial begin
    int len, bri, rri, lhi, bhi, cnt, mism, fs_cnt;
    bit got;
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R12 reset state
    check({rclk_o, bclk_o, lrclk_o, frame_start_o, cfg_err_o} == 5'b0, "R12 reset idle",
          int'({rclk_o, bclk_o, lrclk_o, frame_start_o, cfg_err_o}), 0);

    // R1 R2 R3 directed ratios and prescaler
    trial("R1 code0", "R2 code0", 0, 0, 0, 0, 0, 0, 0, 0);
    trial("R1 code1", "R2 code2", 0, 0, 1, 0, 2, 0, 1, 1);
    trial("R1 code2", "R2 code1", 0, 0, 2, 0, 1, 0, 2, 1);
    trial("R1 code3", "R2 code3", 0, 0, 3, 0, 3, 1, 0, 1);
    trial("R3 enable clear", "R2 code0", 0, 0, 0, 0, 0, 0, 5, 0);
    trial("R3 odd div", "R2 code0", 0, 0, 2, 0, 0, 0, 1, 1);

    // R4 illegal combinations
    trial("R4", "R4", 0, 0, 0, 0, 0, 2, 0, 0);
    trial("R4", "R4", 0, 0, 1, 0, 0, 2, 0, 0);
    trial("R4", "R4", 0, 0, 0, 0, 1, 0, 0, 0);
    trial("R4", "R4", 0, 0, 3, 0, 0, 3, 0, 0);

    // R5 R6 auto selection
    trial("R6 auto w8", "R5 auto w8", 1, 0, 3, 0, 1, 1, 0, 0);
    trial("R6 auto w16", "R5 auto w16", 1, 0, 3, 0, 1, 0, 0, 0);
    trial("R6 auto w24", "R5 auto w24", 1, 0, 0, 0, 0, 2, 0, 0);
    trial("R6 requested bit", "R5", 1, 0, 0, 1, 2, 2, 0, 0);
    trial("R6 requested root", "R5 auto w8", 1, 1, 3, 0, 0, 1, 0, 0);

    // R10 change mid-frame
    halt();
    master = 1; auto_sel = 0; rcode = 0; bcode = 0; wcode = 0; psr = '0;
    run = 1;
    wait_fs(got);
    cnt = 0;
    for (int i = 0; i < 10000; i++) begin
      @(negedge clk);
      cnt++;
      if (cnt == 40) rcode = 2'd3;
      if (frame_start_o) break;
    end
    check(cnt == 256, "R10 old frame kept", cnt, 256);
    measure(len, bri, rri, lhi, bhi);
    check(len == 768, "R10 new ratio applied", len, 768);
    wcode = 2'd2; rcode = 2'd0;
    measure(len, bri, rri, lhi, bhi);
    check(len == 768, "R10 illegal change ignored", len, 768);
    check(cfg_err_o == 1'b1, "R10 error while running", int'(cfg_err_o), 1);

    // R13 stop
    wcode = 2'd0;
    repeat (37) @(negedge clk);
    run = 0;
    @(negedge clk);
    mism = 0;
    for (int i = 0; i < 20; i++) begin
      if (rclk_o || bclk_o || lrclk_o) mism++;
      @(negedge clk);
    end
    check(mism == 0, "R13 stop", mism, 0);

    // R11 slave pass-through
    master = 0; run = 1;
    repeat (4) @(negedge clk);
    mism = 0; fs_cnt = 0;
    for (int i = 0; i < 64; i++) begin
      ebclk = ~ebclk;
      if (i % 8 == 0) elrclk = ~elrclk;
      #1;
      if (bclk_o !== ebclk || lrclk_o !== elrclk || rclk_o !== 1'b0) mism++;
      @(negedge clk);
      if (frame_start_o) fs_cnt++;
    end
    repeat (6) begin @(negedge clk); if (frame_start_o) fs_cnt++; end
    check(mism == 0, "R11 pass-through", mism, 0);
    check(fs_cnt == 4, "R11 slave strobes", fs_cnt, 4);
    check(cfg_err_o == 1'b0, "R11 no error in slave", int'(cfg_err_o), 0);

    // random mix
    for (int k = 0; k < 10; k++) begin
      trial("R1 random", "R2 random", 1'($urandom % 2), 1'($urandom % 2), int'($urandom % 4),
            1'($urandom % 2), int'($urandom % 4), int'($urandom % 4),
            int'($urandom % 3), 1'($urandom % 2));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule